// File: doc/BRIEF.md
# Successive-Approximation Converter Model With Three-Wire Serial Readout

This block is a digital stand-in for a 16-bit differential successive-approximation converter as seen from its serial pins. A host lowers the chip-select line. The block captures a signed differential input value, given as a digital word in LSB units. It resolves that value with a binary search, one trial per internal clock, most significant bit first. The twos-complement result is then shifted out on the host's serial clock. When the search and the frame are both finished, the model reports that it is powered down until the next select.

The chip-select and serial clock inputs pass through a synchronizer on the internal clock, which must run well above the serial clock. The input word must be held stable from the chip-select fall until the synchronized fall has been seen, which is SYNC_STAGES+1 internal clocks. Each frame returns the sample taken at its own chip-select fall, with no pipeline delay. A frame needs at least 22 falling serial clock edges. The search must finish before the fifth falling edge.

Top module: `sar_serial_adc`

## Requirements
- R1: The input word is captured when the synchronized chip-select fall is seen. Later changes to `ain_i` have no effect on the result of that frame.
- R2: The search makes RES_W trials, one per internal clock. It starts from a single-bit mask at the MSB and moves the mask one place lower on each trial. The offset code that results has its MSB inverted to form the twos-complement output.
- R3: Output coding is twos complement in LSB units. An input of 0 gives 0x0000, +1 gives 0x0001, and -1 gives 0xFFFF. Any in-range value v gives v modulo 2^16.
- R4: Inputs above +32767 saturate to 0x7FFF. Inputs at or below -32768 give 0x8000.
- R5: While chip select is high, `dout_en_o` is low and `dout_o` is 0. Serial clock activity in this state changes neither output.
- R6: Counting from the chip-select fall, `dout_en_o` stays low through the fourth falling serial clock edge. It rises with `dout_o`=0 after the fifth falling edge.
- R7: Falling edges 6 to 21 put result bits 15 down to 0 on `dout_o`, one bit per edge, MSB first.
- R8: From falling edge 22 until chip select rises, `dout_o` is 0 and `dout_en_o` stays high.
- R9: `pwrdn_o` is low from the chip-select fall until both the search and edge 22 are done. It is high in idle and once the frame is complete.
- R10: A chip-select rise before edge 22 aborts the frame. `dout_en_o` drops, `pwrdn_o` returns high, and the next frame runs normally.
- R11: Back-to-back frames each return the value sampled at their own chip-select fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal conversion clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low; its fall starts a conversion |
| sclk_i | input | 1 | Host serial clock |
| ain_i | input | RES_W+1 | Signed differential input in LSB units |
| dout_o | output | 1 | Serial data |
| dout_en_o | output | 1 | Data output enable; low means high impedance |
| pwrdn_o | output | 1 | High while neither a conversion nor a transfer is in progress |

## Verification
The bench covers the coding boundaries: 0, +1 and -1, both full-scale codes, and values just past each rail, including the 17-bit extremes. A search that compares unsigned, or that forgets to invert the MSB, returns 0x8000-offset words or wraps instead of saturating. Edges 4, 5 and 22 are sampled on their own, so an off-by-one edge counter shows up as early data or a missing leading zero. The input word is changed right after capture, an abort is issued mid-frame, and the clock is toggled with select high. These expose a design that tracks the live input, leaves the output driven, or starts counting edges outside a frame.

// File: rtl/sarser_pkg.sv
package sarser_pkg;
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_RUN  = 2'd1,
    FR_TAIL = 2'd2
  } fr_state_e;
endpackage

// File: rtl/sarser_sync.sv
module sarser_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES:0] st;
  assign st[0] = d_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st[g+1] <= RST_VAL;
      else         st[g+1] <= st[g];
    end
  end

  assign q_o = st[STAGES];
endmodule

// File: rtl/sarser_sar_core.sv
module sarser_sar_core #(
  parameter int unsigned RES_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic signed [RES_W:0]   ain_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [RES_W-1:0]        code_o
);
  localparam int unsigned CMP_W = RES_W + 2;
  localparam logic signed [CMP_W-1:0] HALF = {2'b00, 1'b1, {(RES_W-1){1'b0}}};
  localparam logic signed [RES_W:0]   MAX_S = {2'b00, {(RES_W-1){1'b1}}};
  localparam logic signed [RES_W:0]   MIN_S = {2'b11, {(RES_W-1){1'b0}}};

  logic signed [RES_W:0] smp_q;
  logic [RES_W-1:0]      acc_q, mask_q, code_q;
  logic                  busy_q, done_q;

  logic [RES_W-1:0]        trial, acc_nx;
  logic signed [CMP_W-1:0] trial_s, smp_ext;
  logic                    keep;

  // comparator model: offset trial code mapped back to signed scale
  always_comb begin
    trial   = acc_q | mask_q;
    trial_s = $signed({2'b00, trial}) - HALF;
    smp_ext = {smp_q[RES_W], smp_q};
    keep    = (smp_ext >= trial_s);
    acc_nx  = keep ? trial : acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= '0;
      acc_q  <= '0;
      mask_q <= '0;
      code_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      smp_q  <= ain_i;
      acc_q  <= '0;
      mask_q <= {1'b1, {(RES_W-1){1'b0}}};
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      acc_q  <= acc_nx;
      mask_q <= mask_q >> 1;
      if (mask_q[0]) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        code_q <= {~acc_nx[RES_W-1], acc_nx[RES_W-2:0]};
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign code_o = code_q;

  AST_SAR_MASK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> $countones(mask_q) == 1); // R2
  AST_SAR_MASK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !mask_q[0] && !start_i |=> busy_q && mask_q == ($past(mask_q) >> 1)); // R2
  AST_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && (smp_q > MAX_S) |-> code_q == {1'b0, {(RES_W-1){1'b1}}}); // R4
  AST_SAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && (smp_q <= MIN_S) |-> code_q == {1'b1, {(RES_W-1){1'b0}}}); // R4
  AST_MIDSCALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && (smp_q == '0) |-> code_q == '0); // R3
endmodule

// File: rtl/sarser_frame.sv
module sarser_frame
  import sarser_pkg::*;
#(
  parameter int unsigned RES_W      = 16,
  parameter int unsigned LEAD_EDGES = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_low_i,
  input  logic             start_i,
  input  logic             sclk_lvl_i,
  input  logic [RES_W-1:0] code_i,
  output logic             active_o,
  output logic             dout_o,
  output logic             oe_o
);
  localparam int unsigned LAST_EDGE = LEAD_EDGES + RES_W + 1;
  localparam int unsigned CNT_W     = $clog2(LAST_EDGE + 1);
  localparam logic [CNT_W-1:0] LEAD_C = CNT_W'(LEAD_EDGES);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST_EDGE);

  fr_state_e        st_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [RES_W-1:0] sh_q;
  logic             dout_q, oe_q, sclk_prev_q, sclk_fall;

  assign sclk_fall = sclk_prev_q & ~sclk_lvl_i;
  assign cnt_nx    = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= FR_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      dout_q      <= 1'b0;
      oe_q        <= 1'b0;
      sclk_prev_q <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_lvl_i;
      if (!cs_low_i) begin
        st_q   <= FR_IDLE;
        cnt_q  <= '0;
        oe_q   <= 1'b0;
        dout_q <= 1'b0;
      end else if (start_i) begin
        st_q   <= FR_RUN;
        cnt_q  <= '0;
        oe_q   <= 1'b0;
        dout_q <= 1'b0;
      end else if (st_q == FR_RUN && sclk_fall) begin
        cnt_q <= cnt_nx;
        if (cnt_nx == LEAD_C) begin
          oe_q   <= 1'b1;
          dout_q <= 1'b0;
          sh_q   <= code_i;
        end else if (cnt_nx == LAST_C) begin
          dout_q <= 1'b0;
          st_q   <= FR_TAIL;
        end else if (cnt_nx > LEAD_C) begin
          dout_q <= sh_q[RES_W-1];
          sh_q   <= sh_q << 1;
        end
      end
    end
  end

  assign active_o = (st_q == FR_RUN);
  assign dout_o   = dout_q;
  assign oe_o     = oe_q;

  AST_OE_AFTER_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q && st_q == FR_RUN |-> cnt_q >= LEAD_C); // R6
  AST_TAIL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == FR_TAIL |-> oe_q && !dout_q); // R8
  AST_HIZ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_q |-> !dout_q); // R5
endmodule

// File: rtl/sar_serial_adc.sv
module sar_serial_adc #(
  parameter int unsigned RES_W       = 16,
  parameter int unsigned LEAD_EDGES  = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_n_i,
  input  logic                  sclk_i,
  input  logic signed [RES_W:0] ain_i,
  output logic                  dout_o,
  output logic                  dout_en_o,
  output logic                  pwrdn_o
);
  logic cs_n_s, cs_prev_q, cs_fall, sclk_s;
  logic busy, done, active;
  logic [RES_W-1:0] code;

  sarser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_n_i), .q_o(cs_n_s));

  sarser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(sclk_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_prev_q <= 1'b1;
    else         cs_prev_q <= cs_n_s;
  end

  assign cs_fall = cs_prev_q & ~cs_n_s;

  sarser_sar_core #(.RES_W(RES_W)) u_sar (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(cs_fall), .ain_i(ain_i),
    .busy_o(busy), .done_o(done), .code_o(code));

  sarser_frame #(.RES_W(RES_W), .LEAD_EDGES(LEAD_EDGES)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_low_i(~cs_n_s), .start_i(cs_fall),
    .sclk_lvl_i(sclk_s), .code_i(code), .active_o(active),
    .dout_o(dout_o), .oe_o(dout_en_o));

  assign pwrdn_o = ~busy & ~active;

  AST_HIZ_ON_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s |=> !dout_en_o); // R5
  AST_PD_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> !pwrdn_o); // R9
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !busy && $past(busy)); // R2
endmodule

// File: tb/sar_serial_adc_test.sv
module sar_serial_adc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic signed [16:0] ain = '0;
  logic dout, dout_en, pwrdn;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [15:0] exp_q[$];
  logic [15:0] rx_word;
  event word_ev;

  always #5 clk = ~clk;

  sar_serial_adc uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .ain_i(ain),
    .dout_o(dout), .dout_en_o(dout_en), .pwrdn_o(pwrdn));

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] model(input logic signed [16:0] v);
    if (v > 17'sd32767)       return 16'h7FFF; // R4
    else if (v < -17'sd32768) return 16'h8000; // R4
    else                      return v[15:0];  // R3
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      @(word_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected word", {16'h0, rx_word}, 32'h0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rx_word == e, "R7 word", {16'h0, rx_word}, {16'h0, e});
      end
    end
  end

  task automatic do_frame(input logic signed [16:0] v, input int n_edges,
                          input bit disturb);
    ain = v;
    if (n_edges >= 22) exp_q.push_back(model(v));
    clks(2);
    cs_n = 1'b0;
    clks(6);
    check(pwrdn == 1'b0, "R9 busy after select", {31'h0, pwrdn}, 32'h0);
    if (disturb) ain = ~v; // R1: change after capture must not matter
    clks(30);
    rx_word = '0;
    for (int k = 1; k <= n_edges; k++) begin
      sclk = 1'b1;
      clks(8);
      sclk = 1'b0;
      clks(8);
      if (k < 5) begin
        check(dout_en == 1'b0, "R6 early enable", {31'h0, dout_en}, 32'h0);
      end else if (k == 5) begin
        check(dout_en && !dout, "R6 lead zero", {30'h0, dout_en, dout}, 32'h2);
      end else if (k <= 21) begin
        rx_word[21-k] = dout;
        if (k == 10)
          check(pwrdn == 1'b0, "R9 low in transfer", {31'h0, pwrdn}, 32'h0);
      end else begin
        check(dout_en && !dout, "R8 tail low", {30'h0, dout_en, dout}, 32'h2);
      end
    end
    if (n_edges >= 22) begin
      check(pwrdn == 1'b1, "R9 high after frame", {31'h0, pwrdn}, 32'h1);
      -> word_ev;
    end
    cs_n = 1'b1;
    clks(6);
    check(dout_en == 1'b0 && dout == 1'b0, "R10 release", {30'h0, dout_en, dout}, 32'h0);
    check(pwrdn == 1'b1, "R10 idle power-down", {31'h0, pwrdn}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clks(4);
    rst_n = 1'b1;
    clks(4);
    check(dout_en == 1'b0 && dout == 1'b0, "R5 reset hiz", {30'h0, dout_en, dout}, 32'h0);
    check(pwrdn == 1'b1, "R9 reset power-down", {31'h0, pwrdn}, 32'h1);

    // R5: serial clock with select high
    for (int i = 0; i < 6; i++) begin
      sclk = 1'b1; clks(4);
      sclk = 1'b0; clks(4);
      check(dout_en == 1'b0 && dout == 1'b0, "R5 sclk ignored", {30'h0, dout_en, dout}, 32'h0);
    end

    do_frame(17'sd0, 24, 1'b0);       // R3 midscale
    do_frame(17'sd1, 24, 1'b0);       // R3 +1
    do_frame(-17'sd1, 24, 1'b0);      // R3 -1
    do_frame(17'sd32767, 24, 1'b0);   // R4 top code
    do_frame(17'sd32768, 24, 1'b0);   // R4 just over
    do_frame(17'sd65535, 24, 1'b0);   // R4 extreme
    do_frame(-17'sd32768, 24, 1'b0);  // R4 bottom code
    do_frame(-17'sd32769, 24, 1'b0);  // R4 just under
    do_frame(-17'sd65536, 24, 1'b0);  // R4 extreme
    do_frame(17'sd12345, 22, 1'b1);   // R1 R2 capture held
    do_frame(-17'sd20000, 22, 1'b1);  // R1 R2
    do_frame(17'sd21845, 10, 1'b0);   // R10 abort mid-frame
    do_frame(-17'sd10923, 24, 1'b0);  // R10 recovery
    do_frame(17'sd256, 22, 1'b0);     // R11 back-to-back
    do_frame(-17'sd3, 22, 1'b0);      // R11
    do_frame(17'sd32766, 22, 1'b0);   // R11

    clks(2);
    check(exp_q.size() == 0, "R11 all words seen", exp_q.size(), 32'h0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule